// File: doc/BRIEF.md
# Ethernet Receive Frame Collector

This block sits on the MAC side of a media-independent receive interface and turns the PHY's receive lanes into a byte stream with frame markers. It works in one of two lane modes. In the narrow mode, used at 10/100 speed, each receive cycle carries 4 bits. In the wide mode, used at gigabit speed, each cycle carries a full byte. A single datapath serves both modes. A frame opens on the rising edge of the receive-valid input and lasts for as long as that input stays high.

While a frame is in progress, the PHY can flag a receive error at any point. In half duplex, a collision also spoils the frame. Normally such a frame is thrown away. Setting a pass-through control delivers it complete instead, with a bad marker on its closing beat, which suits promiscuous capture.

The block also emits two single-cycle pulses for statistics counters. One counts receive-error cycles. The other counts frames that were discarded.

Top module: `eth_rx_collector`

## Requirements
- R1: In wide mode (`cfg_byte_mode`=1), every cycle with `rx_dv` high delivers `rxd` as one frame byte. Bytes leave on `out_data` in arrival order. A byte's beat appears one cycle after the next byte of the same frame is sampled, or one cycle after `rx_dv` is first sampled low if it is the last byte.
- R2: In narrow mode (`cfg_byte_mode`=0), only `rxd[3:0]` is used. The first nibble of each pair becomes bits 3:0 of the byte and the second becomes bits 7:4. `rxd[7:4]` is ignored.
- R3: The first beat a frame delivers carries `out_sof`=1. No other beat of that frame carries it. A frame begins on a cycle where `rx_dv` is high after a cycle where it was low.
- R4: The last complete byte of a kept frame carries `out_eof`=1. It appears on the cycle after `rx_dv` is first sampled low. `out_bad` on that beat is 1 exactly when the frame was spoiled.
- R5: `stat_err_pulse` is high for exactly one cycle after each cycle in which `rx_dv` and `rx_er` were both high. `rx_er` while `rx_dv` is low produces no pulse.
- R6: With `cfg_pass_bad`=0, a receive error or an accepted collision during a frame discards the rest of that frame. `stat_drop_pulse` is raised once, on the cycle after the spoiling cycle. If the frame had already delivered a beat, that same cycle carries one abort beat (`out_valid`, `out_eof`, `out_bad` all 1, `out_data`=0). Nothing else from the frame follows.
- R7: With `cfg_pass_bad`=1, a spoiled frame is delivered in full, with `out_bad`=1 on its closing beat and no drop pulse.
- R8: With `cfg_full_duplex`=1, `rx_col` has no effect on any output.
- R9: A narrow-mode frame with an odd nibble count is spoiled. The trailing nibble is dropped. In pass-through it closes with a bad beat; otherwise it ends as in R6, one cycle after `rx_dv` falls.
- R10: A frame that completes no byte delivers no beat. It raises `stat_drop_pulse` one cycle after `rx_dv` falls.
- R11: While `rst_n` is low at a clock edge, all outputs are driven to 0 and any partial frame is forgotten.
- R12: `out_sof` and `out_eof` occur only with `out_valid`. `out_bad` occurs only on a beat with `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte_mode | input | 1 | 1: byte lanes (gigabit); 0: nibble lanes (10/100) |
| cfg_full_duplex | input | 1 | 1: collision input ignored |
| cfg_pass_bad | input | 1 | 1: deliver spoiled frames marked bad instead of dropping them |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rx_col | input | 1 | Collision indication from the PHY |
| rxd | input | DATA_W | Receive data lanes |
| out_valid | output | 1 | Output beat present |
| out_data | output | DATA_W | Output byte |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Closing beat of a frame |
| out_bad | output | 1 | Frame spoiled; qualifies `out_eof` |
| stat_err_pulse | output | 1 | One pulse per receive-error cycle |
| stat_drop_pulse | output | 1 | One pulse per discarded frame |

## Verification
The bench targets several corner cases:
- Errors on the very first cycle of a frame. A design that emits the abort beat too eagerly would produce a stray end marker for a frame that never started.
- Frames of one byte and frames of a single nibble. These expose wrong start/end pairing or a missing drop pulse.
- Odd nibble counts in both bad-frame modes. A design that forgot the pending half-byte would close such frames as clean.
- Collisions that arrive in full duplex, and frames separated by a single idle cycle. Either would show up as leaked state between frames.
- A reset in the middle of a frame. A stale held byte would then surface in the next frame.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

   typedef struct packed {
      logic sof;
      logic eof;
      logic bad;
   } beat_flags_t;

   typedef enum logic {
      LANE_NIBBLE = 1'b0,
      LANE_BYTE   = 1'b1
   } lane_mode_e;

endpackage

// File: rtl/eth_rx_lane_asm.sv
module eth_rx_lane_asm #(
   parameter int DATA_W         = 8,
   parameter bit SUPPORT_NIBBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              dv,
   input  logic              frame_start,
   input  logic [DATA_W-1:0] rxd,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_dat,
   output logic              odd_left
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (SUPPORT_NIBBLE) begin : g_dual
         logic              half_q;
         logic              cur_half;
         logic [HALF_W-1:0] low_q;

         // a new frame always starts on the low half
         assign cur_half = frame_start ? 1'b0 : half_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               half_q <= 1'b0;
               low_q  <= '0;
            end else if (dv) begin
               if (byte_mode == eth_rx_pkg::LANE_BYTE) begin
                  half_q <= 1'b0;
               end else begin
                  half_q <= ~cur_half;
                  if (!cur_half) low_q <= rxd[HALF_W-1:0];
               end
            end
         end

         assign byte_vld = dv & (byte_mode | cur_half);
         assign byte_dat = byte_mode ? rxd : {rxd[HALF_W-1:0], low_q};
         assign odd_left = half_q & ~byte_mode;
      end else begin : g_byte_only
         logic unused_sig;
         assign unused_sig = ^{clk, rst_n, byte_mode, frame_start};
         assign byte_vld   = dv;
         assign byte_dat   = rxd;
         assign odd_left   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/eth_rx_err_qual.sv
module eth_rx_err_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic dv,
   input  logic frame_start,
   input  logic rx_er,
   input  logic rx_col,
   input  logic full_duplex,
   output logic bad_prev,
   output logic bad_now,
   output logic err_pulse
);
   logic bad_q;
   logic col_eff;

   assign col_eff  = rx_col & ~full_duplex;
   assign bad_prev = frame_start ? 1'b0 : bad_q;
   assign bad_now  = bad_prev | (dv & (rx_er | col_eff));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_q     <= 1'b0;
         err_pulse <= 1'b0;
      end else begin
         if (dv) bad_q <= bad_now;
         err_pulse <= dv & rx_er;
      end
   end
endmodule

// File: rtl/eth_rx_beat_emit.sv
module eth_rx_beat_emit #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pass_bad,
   input  logic              dv,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_dat,
   input  logic              bad_prev,
   input  logic              bad_now,
   input  logic              odd_left,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_bad,
   output logic              drop_pulse
);
   import eth_rx_pkg::*;

   logic              hold_v_q;
   logic              emitted_q;
   logic [DATA_W-1:0] hold_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   beat_flags_t       flags_q;
   logic              drop_q;

   logic em_c, hv_c, discard_now, newly_drop;
   logic end_bad, already_dropped, end_drop;

   assign em_c            = frame_start ? 1'b0 : emitted_q;
   assign hv_c            = frame_start ? 1'b0 : hold_v_q;
   assign discard_now     = bad_now & ~pass_bad;
   assign newly_drop      = discard_now & ~bad_prev;
   assign end_bad         = bad_prev | odd_left;
   assign already_dropped = bad_prev & ~pass_bad;
   assign end_drop        = (end_bad & ~pass_bad) | ~hold_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v_q  <= 1'b0;
         emitted_q <= 1'b0;
         hold_q    <= '0;
         valid_q   <= 1'b0;
         data_q    <= '0;
         flags_q   <= '0;
         drop_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         data_q  <= '0;
         flags_q <= '0;
         drop_q  <= 1'b0;
         if (dv) begin
            if (discard_now) begin
               hold_v_q  <= 1'b0;
               emitted_q <= em_c;
               if (newly_drop) begin
                  drop_q <= 1'b1;
                  if (em_c) begin
                     valid_q     <= 1'b1;
                     flags_q.eof <= 1'b1;
                     flags_q.bad <= 1'b1;
                  end
               end
            end else if (byte_vld) begin
               hold_q    <= byte_dat;
               hold_v_q  <= 1'b1;
               emitted_q <= em_c | hv_c;
               if (hv_c) begin
                  valid_q     <= 1'b1;
                  data_q      <= hold_q;
                  flags_q.sof <= ~em_c;
               end
            end else begin
               hold_v_q  <= hv_c;
               emitted_q <= em_c;
            end
         end else if (frame_end) begin
            hold_v_q  <= 1'b0;
            emitted_q <= 1'b0;
            if (!already_dropped) begin
               if (end_drop) begin
                  drop_q <= 1'b1;
                  if (emitted_q) begin
                     valid_q     <= 1'b1;
                     flags_q.eof <= 1'b1;
                     flags_q.bad <= 1'b1;
                  end
               end else begin
                  valid_q     <= 1'b1;
                  data_q      <= hold_q;
                  flags_q.sof <= ~emitted_q;
                  flags_q.eof <= 1'b1;
                  flags_q.bad <= end_bad;
               end
            end
         end
      end
   end

   assign out_valid  = valid_q;
   assign out_data   = data_q;
   assign out_sof    = flags_q.sof;
   assign out_eof    = flags_q.eof;
   assign out_bad    = flags_q.bad;
   assign drop_pulse = drop_q;
endmodule

// File: rtl/eth_rx_collector.sv
module eth_rx_collector #(
   parameter int DATA_W         = 8,
   parameter bit SUPPORT_NIBBLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_byte_mode,
   input  logic              cfg_full_duplex,
   input  logic              cfg_pass_bad,
   input  logic              rx_dv,
   input  logic              rx_er,
   input  logic              rx_col,
   input  logic [DATA_W-1:0] rxd,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_bad,
   output logic              stat_err_pulse,
   output logic              stat_drop_pulse
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 2 || (HALF_W * 2) != DATA_W) begin : g_bad_width
         $error("eth_rx_collector: DATA_W must be an even value of at least 2");
      end
   endgenerate

   logic              dv_q;
   logic              frame_start, frame_end;
   logic              byte_vld, odd_left;
   logic [DATA_W-1:0] byte_dat;
   logic              bad_prev, bad_now;

   always_ff @(posedge clk) begin
      if (!rst_n) dv_q <= 1'b0;
      else        dv_q <= rx_dv;
   end

   assign frame_start = rx_dv & ~dv_q;
   assign frame_end   = ~rx_dv & dv_q;

   eth_rx_lane_asm #(.DATA_W(DATA_W), .SUPPORT_NIBBLE(SUPPORT_NIBBLE)) u_asm (
      .clk(clk), .rst_n(rst_n), .byte_mode(cfg_byte_mode), .dv(rx_dv),
      .frame_start(frame_start), .rxd(rxd), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .odd_left(odd_left)
   );

   eth_rx_err_qual u_qual (
      .clk(clk), .rst_n(rst_n), .dv(rx_dv), .frame_start(frame_start),
      .rx_er(rx_er), .rx_col(rx_col), .full_duplex(cfg_full_duplex),
      .bad_prev(bad_prev), .bad_now(bad_now), .err_pulse(stat_err_pulse)
   );

   eth_rx_beat_emit #(.DATA_W(DATA_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .pass_bad(cfg_pass_bad), .dv(rx_dv),
      .frame_start(frame_start), .frame_end(frame_end), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .bad_prev(bad_prev), .bad_now(bad_now),
      .odd_left(odd_left), .out_valid(out_valid), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_bad(out_bad),
      .drop_pulse(stat_drop_pulse)
   );
endmodule

// File: rtl/eth_rx_collector_chk.sv
module eth_rx_collector_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_pass_bad,
   input logic rx_dv,
   input logic rx_er,
   input logic out_valid,
   input logic out_sof,
   input logic out_eof,
   input logic out_bad,
   input logic stat_err_pulse,
   input logic stat_drop_pulse
);
   assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_dv && rx_er) |=> stat_err_pulse);

   assert_no_spurious_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_dv && rx_er) |=> !stat_err_pulse);

   assert_bad_only_on_eof_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad |-> (out_eof && out_valid));

   assert_markers_need_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eof) |-> out_valid);

   assert_clean_eof_after_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_eof && !out_bad) |-> !$past(rx_dv));

   assert_abort_counts_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_bad && !$past(cfg_pass_bad)) |-> stat_drop_pulse);

   assert_pass_keeps_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_drop_pulse && $past(cfg_pass_bad)) |-> !out_valid);
endmodule

bind eth_rx_collector eth_rx_collector_chk u_chk (.*);

// File: tb/eth_rx_collector_tb.sv
`timescale 1ns/1ps
module eth_rx_collector_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_byte_mode = 1'b1, cfg_full_duplex = 1'b0, cfg_pass_bad = 1'b0;
   logic       rx_dv = 1'b0, rx_er = 1'b0, rx_col = 1'b0;
   logic [7:0] rxd = '0;
   logic       out_valid, out_sof, out_eof, out_bad, stat_err_pulse, stat_drop_pulse;
   logic [7:0] out_data;

   always #10 clk = ~clk;

   eth_rx_collector u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
      .cfg_full_duplex(cfg_full_duplex), .cfg_pass_bad(cfg_pass_bad),
      .rx_dv(rx_dv), .rx_er(rx_er), .rx_col(rx_col), .rxd(rxd),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .out_bad(out_bad), .stat_err_pulse(stat_err_pulse),
      .stat_drop_pulse(stat_drop_pulse)
   );

   int    n_checks = 0, n_errs = 0;
   bit    done = 1'b0;
   string scen = "R11 reset";

   // behavioural reference model
   bit         m_active = 0, m_bad = 0, m_dropped = 0;
   int         m_nib = 0, m_emitted = 0;
   logic [3:0] m_low = '0;
   logic [7:0] m_pend[$];
   bit         e_valid = 0, e_sof = 0, e_eof = 0, e_bad = 0, e_err = 0, e_drop = 0;
   logic [7:0] e_data = '0;

   task automatic m_beat(input logic [7:0] d, input bit s, input bit e, input bit b);
      e_valid = 1; e_data = d; e_sof = s; e_eof = e; e_bad = b;
   endtask

   always @(posedge clk) begin
      e_valid = 0; e_data = '0; e_sof = 0; e_eof = 0; e_bad = 0; e_err = 0; e_drop = 0;
      if (!rst_n) begin
         m_active = 0; m_bad = 0; m_dropped = 0; m_nib = 0; m_emitted = 0;
         m_pend.delete();
      end else if (rx_dv) begin
         bit         have;
         logic [7:0] nb;
         have = 0; nb = '0;
         e_err = rx_er;
         if (!m_active) begin
            m_active = 1; m_bad = 0; m_dropped = 0; m_nib = 0; m_emitted = 0;
            m_pend.delete();
         end
         if ((rx_er || (rx_col && !cfg_full_duplex)) && !m_bad) begin
            m_bad = 1;
            if (!cfg_pass_bad) begin
               m_dropped = 1; e_drop = 1;
               if (m_emitted > 0) m_beat(8'h00, 0, 1, 1);
               m_pend.delete();
            end
         end
         if (!m_dropped) begin
            if (cfg_byte_mode) begin
               nb = rxd; have = 1;
            end else begin
               if (m_nib % 2 == 0) m_low = rxd[3:0];
               else begin nb = {rxd[3:0], m_low}; have = 1; end
               m_nib++;
            end
            if (have) begin
               if (m_pend.size() > 0) begin
                  m_beat(m_pend.pop_front(), m_emitted == 0, 0, 0);
                  m_emitted++;
               end
               m_pend.push_back(nb);
            end
         end
      end else if (m_active) begin
         bit fin;
         m_active = 0;
         if (!m_dropped) begin
            fin = m_bad || (!cfg_byte_mode && (m_nib % 2 == 1));
            if ((fin && !cfg_pass_bad) || m_pend.size() == 0) begin
               e_drop = 1;
               if (m_emitted > 0) m_beat(8'h00, 0, 1, 1);
            end else begin
               m_beat(m_pend.pop_front(), m_emitted == 0, 1, fin);
            end
         end
         m_pend.delete();
      end
   end

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL [%s] %s act=%h exp=%h at %0t", scen, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("out_valid", {7'd0, out_valid}, {7'd0, e_valid});
         chk("out_data", out_data, e_data);
         chk("out_sof", {7'd0, out_sof}, {7'd0, e_sof});
         chk("out_eof", {7'd0, out_eof}, {7'd0, e_eof});
         chk("out_bad", {7'd0, out_bad}, {7'd0, e_bad});
         chk("stat_err_pulse", {7'd0, stat_err_pulse}, {7'd0, e_err});
         chk("stat_drop_pulse", {7'd0, stat_drop_pulse}, {7'd0, e_drop});
      end
   end

   task automatic cyc(input bit dv, input bit er, input bit col, input logic [7:0] d);
      @(negedge clk);
      rx_dv = dv; rx_er = er; rx_col = col; rxd = d;
   endtask

   task automatic frame(input int n, input int er_at, input int col_at,
                        input int seed, input int gap);
      for (int i = 0; i < n; i++)
         cyc(1'b1, i == er_at, i == col_at, 8'((seed * 29 + i * 11 + 5) & 255));
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_errs++;
         $display("FAIL [watchdog] run did not finish act=hung exp=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0);

      scen = "R1 byte stream";
      frame(6, -1, -1, 1, 3);
      frame(9, -1, -1, 2, 2);
      scen = "R3 R4 single byte frame";
      frame(1, -1, -1, 3, 3);

      scen = "R2 nibble assembly";
      cfg_byte_mode = 1'b0;
      frame(12, -1, -1, 4, 3);
      frame(2, -1, -1, 5, 3);

      scen = "R5 error pulses";
      cfg_byte_mode = 1'b1; cfg_pass_bad = 1'b1;
      frame(6, 2, -1, 6, 2);
      cyc(0, 1, 0, 8'h11);
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);

      scen = "R6 drop on error";
      cfg_pass_bad = 1'b0;
      frame(8, 3, -1, 7, 3);
      frame(5, 0, -1, 8, 3);
      cfg_byte_mode = 1'b0;
      frame(10, 5, -1, 9, 3);
      cfg_byte_mode = 1'b1;
      scen = "R6 collision drop";
      frame(7, -1, 4, 10, 3);

      scen = "R7 pass-through collision";
      cfg_pass_bad = 1'b1;
      frame(7, -1, 2, 11, 3);
      frame(4, 3, -1, 12, 3);

      scen = "R8 collision ignored full duplex";
      cfg_pass_bad = 1'b0; cfg_full_duplex = 1'b1;
      frame(7, -1, 3, 13, 3);
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 8'(i * 7 + 3));
      cyc(0, 0, 1, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cfg_full_duplex = 1'b0;

      scen = "R9 odd nibble count";
      cfg_byte_mode = 1'b0; cfg_pass_bad = 1'b1;
      frame(7, -1, -1, 14, 3);
      cfg_pass_bad = 1'b0;
      frame(9, -1, -1, 15, 3);

      scen = "R10 no complete byte";
      frame(1, -1, -1, 16, 3);
      cfg_pass_bad = 1'b1;
      frame(1, -1, -1, 17, 3);
      cfg_pass_bad = 1'b0;

      scen = "R3 R12 back-to-back frames";
      cfg_byte_mode = 1'b1;
      frame(4, -1, -1, 18, 1);
      frame(3, -1, -1, 19, 1);
      frame(2, 1, -1, 20, 1);
      frame(5, -1, -1, 21, 3);

      scen = "R11 reset mid frame";
      frame(3, -1, -1, 22, 0);
      @(negedge clk);
      rst_n = 1'b0; rx_dv = 1'b0;
      cyc(0, 0, 0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      frame(4, -1, -1, 23, 3);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule